// File: doc/BRIEF.md
# Byte Bit-Manipulation Execution Unit

This unit carries out single-bit operations on one byte for a small 16-bit CPU datapath. Each accepted request names one of eight operations, supplies the operand byte (fetched from a register or from memory by logic outside the unit), a bit number and the current carry and zero flags. One clock later the unit presents the byte to store back together with a store strobe, and the new carry and zero flags.

There are three kinds of operation. Set, clear and invert rewrite one bit of the byte and request a store. Test copies the complement of one bit into the zero flag. Four carry-logic operations combine the carry flag with one bit, or with its complement, using AND or OR. The bit number is taken either from an immediate field or from the low bits of a general register. The carry-logic operations accept only the immediate form. If one of them arrives with the register form, the unit raises an illegal-operand flag and changes nothing.

Top module: `bitop_unit`

## Requirements
- R1: While reset is applied, valid_out, result, wr_en, c_out, z_out and illegal are all 0.
- R2: A request is taken on a rising edge when valid_in is 1, and its outputs are presented with valid_out=1 after that edge. An edge with valid_in=0 gives valid_out=0 and leaves result, wr_en, c_out, z_out and illegal unchanged.
- R3: The opcode encoding is 0 set, 1 clear, 2 invert, 3 test, 4 carry-AND, 5 carry-AND-inverted, 6 carry-OR, 7 carry-OR-inverted. The bit number is reg_bitno when bit_src_reg=1 and bit_imm when bit_src_reg=0.
- R4: Set returns the operand with the selected bit forced to 1, with wr_en=1.
- R5: Clear returns the operand with the selected bit forced to 0, with wr_en=1.
- R6: Invert returns the operand with the selected bit complemented, with wr_en=1.
- R7: Test sets z_out to the complement of the selected bit. It returns the operand unchanged, with wr_en=0.
- R8: With an immediate bit number, carry-AND sets c_out to c_in AND the bit, and carry-AND-inverted sets c_out to c_in AND NOT the bit.
- R9: With an immediate bit number, carry-OR sets c_out to c_in OR the bit, and carry-OR-inverted sets c_out to c_in OR NOT the bit.
- R10: Opcodes 4 to 7 with bit_src_reg=1 give illegal=1, c_out=c_in, z_out=z_in and wr_en=0, and result equals the operand. Every other request gives illegal=0.
- R11: wr_en is 1 only for opcodes 0 to 2, and for opcodes 3 to 7 result equals the operand. c_out equals c_in except for a legal carry-logic request. z_out equals z_in except for test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| valid_in | input | 1 | Request strobe |
| opcode | input | 3 | Operation code (see R3) |
| operand | input | DATA_W | Operand byte |
| bit_imm | input | IDX_W | Immediate bit number |
| bit_src_reg | input | 1 | 1 selects the register-sourced bit number |
| reg_bitno | input | IDX_W | Low bits of the general register that holds the bit number |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| valid_out | output | 1 | Result strobe, one cycle after the request |
| result | output | DATA_W | Byte to store back |
| wr_en | output | 1 | Store-back request |
| c_out | output | 1 | New carry flag |
| z_out | output | 1 | New zero flag |
| illegal | output | 1 | Carry-logic request used a register bit number |

## Verification
Every opcode is run with every bit number, both bit-number sources, all four combinations of the incoming flags, and operand bytes 00, FF, A5, 5A, 01 and 80. Operands with all bits 0 or all bits 1 show whether the correct bit value reaches the carry and zero logic. The alternating patterns and the single-bit bytes show whether set, clear and invert touch only the selected position. When the register source is chosen, the immediate field always carries the complement of the intended bit number, so a wrong selection shows up as a wrong bit. Idle cycles are placed among the back-to-back requests to confirm that the outputs hold their values and that the strobe drops.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [2:0] {
    OP_SET   = 3'd0,
    OP_CLR   = 3'd1,
    OP_INV   = 3'd2,
    OP_TST   = 3'd3,
    OP_CAND  = 3'd4,
    OP_CANDN = 3'd5,
    OP_COR   = 3'd6,
    OP_CORN  = 3'd7
  } bitop_e;

  // opcodes whose result is stored back to the operand location
  function automatic logic is_rmw(bitop_e op);
    return (op == OP_SET) || (op == OP_CLR) || (op == OP_INV);
  endfunction

  // carry-logic group: immediate bit number only
  function automatic logic is_carry(bitop_e op);
    return (op == OP_CAND) || (op == OP_CANDN) ||
           (op == OP_COR)  || (op == OP_CORN);
  endfunction

endpackage

// File: rtl/bitop_rst_sync.sv
module bitop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bitop_bit_sel.sv
module bitop_bit_sel #(
  parameter  int DATA_W = 8,
  localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [IDX_W-1:0]  bit_imm,
  input  logic              bit_src_reg,
  input  logic [IDX_W-1:0]  reg_bitno,
  output logic [DATA_W-1:0] bit_mask,
  output logic              bit_val
);

  logic [IDX_W-1:0] idx;

  assign idx = bit_src_reg ? reg_bitno : bit_imm;

  // one decoder line per bit position
  for (genvar g = 0; g < DATA_W; g++) begin : g_dec
    assign bit_mask[g] = (idx == IDX_W'(g));
  end

  assign bit_val = |(operand & bit_mask);

endmodule

// File: rtl/bitop_byte_op.sv
module bitop_byte_op
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  bitop_e            op,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] bit_mask,
  output logic [DATA_W-1:0] byte_nxt,
  output logic              wr_nxt
);

  always_comb begin
    byte_nxt = operand;
    wr_nxt   = is_rmw(op);
    case (op)
      OP_SET:  byte_nxt = operand | bit_mask;
      OP_CLR:  byte_nxt = operand & ~bit_mask;
      OP_INV:  byte_nxt = operand ^ bit_mask;
      default: byte_nxt = operand;
    endcase
  end

endmodule

// File: rtl/bitop_flag_op.sv
module bitop_flag_op
  import bitop_pkg::*;
(
  input  bitop_e op,
  input  logic   bit_src_reg,
  input  logic   bit_val,
  input  logic   c_in,
  input  logic   z_in,
  output logic   c_nxt,
  output logic   z_nxt,
  output logic   ill_nxt
);

  always_comb begin
    c_nxt   = c_in;
    z_nxt   = z_in;
    ill_nxt = is_carry(op) && bit_src_reg;
    if (!ill_nxt) begin
      case (op)
        OP_TST:   z_nxt = ~bit_val;
        OP_CAND:  c_nxt = c_in &  bit_val;
        OP_CANDN: c_nxt = c_in & ~bit_val;
        OP_COR:   c_nxt = c_in |  bit_val;
        OP_CORN:  c_nxt = c_in | ~bit_val;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [2:0]        opcode,
  input  logic [DATA_W-1:0] operand,
  input  logic [IDX_W-1:0]  bit_imm,
  input  logic              bit_src_reg,
  input  logic [IDX_W-1:0]  reg_bitno,
  input  logic              c_in,
  input  logic              z_in,
  output logic              valid_out,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic              c_out,
  output logic              z_out,
  output logic              illegal
);

  logic              rst_q_n;
  bitop_e            op_e;
  logic [DATA_W-1:0] bit_mask;
  logic              bit_val;
  logic [DATA_W-1:0] byte_nxt;
  logic              wr_nxt;
  logic              c_nxt;
  logic              z_nxt;
  logic              ill_nxt;

  logic              vld_q, vld_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              wr_q, wr_d;
  logic              c_q, c_d;
  logic              z_q, z_d;
  logic              ill_q, ill_d;

  assign op_e = bitop_e'(opcode);

  bitop_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  bitop_bit_sel #(.DATA_W(DATA_W)) u_sel (
    .operand     (operand),
    .bit_imm     (bit_imm),
    .bit_src_reg (bit_src_reg),
    .reg_bitno   (reg_bitno),
    .bit_mask    (bit_mask),
    .bit_val     (bit_val)
  );

  bitop_byte_op #(.DATA_W(DATA_W)) u_byte (
    .op       (op_e),
    .operand  (operand),
    .bit_mask (bit_mask),
    .byte_nxt (byte_nxt),
    .wr_nxt   (wr_nxt)
  );

  bitop_flag_op u_flag (
    .op          (op_e),
    .bit_src_reg (bit_src_reg),
    .bit_val     (bit_val),
    .c_in        (c_in),
    .z_in        (z_in),
    .c_nxt       (c_nxt),
    .z_nxt       (z_nxt),
    .ill_nxt     (ill_nxt)
  );

  // next state: load on an accepted request, otherwise hold
  always_comb begin
    vld_d = valid_in;
    res_d = res_q;
    wr_d  = wr_q;
    c_d   = c_q;
    z_d   = z_q;
    ill_d = ill_q;
    if (valid_in) begin
      res_d = byte_nxt;
      wr_d  = wr_nxt && !ill_nxt;
      c_d   = c_nxt;
      z_d   = z_nxt;
      ill_d = ill_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      wr_q  <= 1'b0;
      c_q   <= 1'b0;
      z_q   <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      wr_q  <= wr_d;
      c_q   <= c_d;
      z_q   <= z_d;
      ill_q <= ill_d;
    end
  end

  assign valid_out = vld_q;
  assign result    = res_q;
  assign wr_en     = wr_q;
  assign c_out     = c_q;
  assign z_out     = z_q;
  assign illegal   = ill_q;

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter  int DATA_W = 8,
  localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              valid_in,
  input logic [2:0]        opcode,
  input logic [DATA_W-1:0] operand,
  input logic [IDX_W-1:0]  bit_imm,
  input logic              bit_src_reg,
  input logic [IDX_W-1:0]  reg_bitno,
  input logic              c_in,
  input logic              z_in,
  input logic              valid_out,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic              c_out,
  input logic              z_out,
  input logic              illegal
);

  logic [IDX_W-1:0]  in_idx;
  logic [DATA_W-1:0] in_mask;
  logic              in_bit;

  assign in_idx  = bit_src_reg ? reg_bitno : bit_imm;
  assign in_mask = DATA_W'(1) << in_idx;
  assign in_bit  = operand[in_idx];

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_q_n)
    valid_in |=> valid_out); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_q_n)
    !valid_in |=> !valid_out); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !valid_in |=> $stable(result) && $stable(c_out) && $stable(z_out) && $stable(wr_en) && $stable(illegal)); // R2
  AST_SET_BIT: assert property (@(posedge clk) disable iff (!rst_q_n)
    valid_in && opcode == 3'd0 |=> wr_en && result == ($past(operand) | $past(in_mask))); // R4
  AST_CLR_BIT: assert property (@(posedge clk) disable iff (!rst_q_n)
    valid_in && opcode == 3'd1 |=> wr_en && result == ($past(operand) & ~$past(in_mask))); // R5
  AST_INV_BIT: assert property (@(posedge clk) disable iff (!rst_q_n)
    valid_in && opcode == 3'd2 |=> wr_en && result == ($past(operand) ^ $past(in_mask))); // R6
  AST_TST_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    valid_in && opcode == 3'd3 |=> z_out == !$past(in_bit) && c_out == $past(c_in)); // R7
  AST_CAND: assert property (@(posedge clk) disable iff (!rst_q_n)
    valid_in && opcode == 3'd4 && !bit_src_reg |=> c_out == ($past(c_in) && $past(in_bit))); // R8
  AST_CORN: assert property (@(posedge clk) disable iff (!rst_q_n)
    valid_in && opcode == 3'd7 && !bit_src_reg |=> c_out == ($past(c_in) || !$past(in_bit))); // R9
  AST_ILLEGAL_NOOP: assert property (@(posedge clk) disable iff (!rst_q_n)
    valid_in && opcode[2] && bit_src_reg |=> illegal && !wr_en && c_out == $past(c_in) && z_out == $past(z_in)); // R10
  AST_LEGAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_q_n)
    valid_in && !(opcode[2] && bit_src_reg) |=> !illegal); // R10
  AST_NO_WR_NONRMW: assert property (@(posedge clk) disable iff (!rst_q_n)
    valid_in && opcode >= 3'd3 |=> !wr_en && result == $past(operand)); // R11
  AST_Z_KEEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    valid_in && opcode != 3'd3 |=> z_out == $past(z_in)); // R11

endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .valid_in    (valid_in),
  .opcode      (opcode),
  .operand     (operand),
  .bit_imm     (bit_imm),
  .bit_src_reg (bit_src_reg),
  .reg_bitno   (reg_bitno),
  .c_in        (c_in),
  .z_in        (z_in),
  .valid_out   (valid_out),
  .result      (result),
  .wr_en       (wr_en),
  .c_out       (c_out),
  .z_out       (z_out),
  .illegal     (illegal)
);

// File: tb/bitop_unit_test.sv
module bitop_unit_test;

  localparam int DATA_W = 8;
  localparam int IDX_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid_in = 1'b0;
  logic [2:0]        opcode = '0;
  logic [DATA_W-1:0] operand = '0;
  logic [IDX_W-1:0]  bit_imm = '0;
  logic              bit_src_reg = 1'b0;
  logic [IDX_W-1:0]  reg_bitno = '0;
  logic              c_in = 1'b0;
  logic              z_in = 1'b0;
  logic              valid_out;
  logic [DATA_W-1:0] result;
  logic              wr_en;
  logic              c_out;
  logic              z_out;
  logic              illegal;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bitop_unit #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .opcode(opcode),
    .operand(operand), .bit_imm(bit_imm), .bit_src_reg(bit_src_reg),
    .reg_bitno(reg_bitno), .c_in(c_in), .z_in(z_in),
    .valid_out(valid_out), .result(result), .wr_en(wr_en),
    .c_out(c_out), .z_out(z_out), .illegal(illegal)
  );

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(int op, bit src);
    if (op >= 4 && src) return "R10";
    case (op)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4, 5: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
    int n = 0;
    logic [7:0] last_res = '0;
    logic last_wr = 0, last_c = 0, last_z = 0, last_ill = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", "valid_out", valid_out, 0);
    check("R1", "result", result, 0);
    check("R1", "wr_en", wr_en, 0);
    check("R1", "c_out", c_out, 0);
    check("R1", "z_out", z_out, 0);
    check("R1", "illegal", illegal, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R2", "valid_out idle", valid_out, 0);

    for (int op = 0; op < 8; op++)
      for (int src = 0; src < 2; src++)
        for (int b = 0; b < 8; b++)
          for (int cz = 0; cz < 4; cz++)
            for (int p = 0; p < 6; p++) begin
              logic [7:0] opnd, mask, eres;
              logic bv, ci, zi, ewr, ec, ez, eill;
              string rq;
              opnd = pats[p];
              ci = cz[0];
              zi = cz[1];
              mask = 8'(1) << b;
              bv = opnd[b];
              // R3 encoding and bit-number source
              valid_in    = 1'b1;
              opcode      = 3'(op);
              operand     = opnd;
              bit_src_reg = src[0];
              bit_imm     = src[0] ? ~3'(b) : 3'(b);
              reg_bitno   = src[0] ? 3'(b) : ~3'(b);
              c_in        = ci;
              z_in        = zi;
              eill = (op >= 4) && src[0];
              eres = opnd;
              if (op == 0) eres = opnd | mask;
              if (op == 1) eres = opnd & ~mask;
              if (op == 2) eres = opnd ^ mask;
              ewr = (op < 3);
              ec = ci;
              if (!eill) begin
                if (op == 4) ec = ci & bv;
                if (op == 5) ec = ci & ~bv;
                if (op == 6) ec = ci | bv;
                if (op == 7) ec = ci | ~bv;
              end
              ez = (op == 3) ? ~bv : zi;
              rq = req_of(op, src[0]);
              @(posedge clk);
              @(negedge clk);
              check("R2", "valid_out", valid_out, 1);
              check(rq, "result", result, eres);
              check("R11", "wr_en", wr_en, ewr);
              check(rq, "c_out", c_out, ec);
              check(rq, "z_out", z_out, ez);
              check("R10", "illegal", illegal, eill);
              last_res = eres; last_wr = ewr; last_c = ec;
              last_z = ez; last_ill = eill;
              n++;
              if (n % 37 == 0) begin
                // R2 idle cycle: strobe drops, outputs hold
                valid_in = 1'b0;
                operand  = ~opnd;
                c_in     = ~ci;
                z_in     = ~zi;
                @(posedge clk);
                @(negedge clk);
                check("R2", "idle valid_out", valid_out, 0);
                check("R2", "idle result", result, last_res);
                check("R2", "idle wr_en", wr_en, last_wr);
                check("R2", "idle c_out", c_out, last_c);
                check("R2", "idle z_out", z_out, last_z);
                check("R2", "idle illegal", illegal, last_ill);
              end
            end

    valid_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2", "final valid_out", valid_out, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule